// File: doc/BRIEF.md
# Flash Block Lock Manager

This block holds the protection state of every erase block in a boot-block flash array. It decides whether a program or erase aimed at a given word address may start. The array is split into small parameter blocks and large main blocks. The parameter blocks take up a single main-block-sized slot, either at the top of the address space or at its bottom, as a parameter selects. The block maps each word address to a block index and keeps one small state machine per block. It also reports the state of the block that the current address selects.

Each block is unlocked, locked or locked-down. Lock, unlock and lock-down commands act on the block that holds the presented address. A write-protect pin level decides whether a locked-down block may leave that state. When an operation-start strobe arrives, the block registers a verdict. The verdict combines the addressed block's state with a program-voltage lockout flag sampled at that moment. It then holds the verdict, so a later change of the flag does not affect an operation already under way.

Top module: `flash_lock_mgr`

## Requirements
- R1: With the bottom-boot layout, block indices 0 to NP-1 are the parameter blocks of 2^PARAM_LOG2 words starting at address 0. Indices NP upward are the main blocks of 2^MAIN_LOG2 words in ascending address order. `blk_index` reports the block that holds `word_addr`.
- R2: With the top-boot layout, indices 0 to NM-1 are the main blocks from address 0 upward. The remaining NP indices are the parameter blocks that fill the highest main-block-sized slot. Index 0 is always the lowest-addressed block.
- R3: `blk_state` encodes the addressed block as 2'b00 unlocked, 2'b01 locked and 2'b11 locked-down. A lock command moves an unlocked block to locked. An unlock command moves a locked block to unlocked. Each command takes effect on the clock edge that samples it.
- R4: A lock-down command moves the addressed block to locked-down from any state.
- R5: While `wp_pin` is 0, lock and unlock commands on a locked-down block leave it locked-down.
- R6: While `wp_pin` is 1, an unlock command moves a locked-down block to unlocked, and a lock command moves it to locked.
- R7: A clock edge with `rst_n` at 0 puts every block in the locked state and clears `verdict_valid` and `verdict_allow`.
- R8: On an edge where `op_start` is 1, `verdict_allow` becomes 1 only if the addressed block is unlocked in the state held before that edge. Locked and locked-down blocks are refused.
- R9: On an edge where `op_start` is 1 and `vpp_lockout` is 1, `verdict_allow` becomes 0 whatever the block state.
- R10: `verdict_valid` is 1 for exactly the cycle after an `op_start` edge. `verdict_allow` keeps its value until the next `op_start`, whatever `vpp_lockout` does in between.
- R11: A command changes only the block that holds `word_addr`. Every other block keeps its state.
- R12: When more than one command is raised in the same cycle, lock-down wins over lock, and lock wins over unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_addr | input | ADDR_W | Word address selecting the target block |
| cmd_lock | input | 1 | Lock command for the addressed block |
| cmd_unlock | input | 1 | Unlock command for the addressed block |
| cmd_lockdown | input | 1 | Lock-down command for the addressed block |
| wp_pin | input | 1 | Write-protect pin level; 0 keeps locked-down blocks fixed |
| vpp_lockout | input | 1 | Program voltage below the lockout threshold |
| op_start | input | 1 | Program or erase start strobe |
| blk_index | output | IDX_W | Index of the block holding `word_addr` |
| blk_state | output | 2 | Protection state of the addressed block |
| verdict_valid | output | 1 | One-cycle pulse after `op_start` |
| verdict_allow | output | 1 | Held result: 1 allows the started operation |

## Verification
The bench builds two copies with a 64-word array (ADDR_W=6, MAIN_LOG2=3, PARAM_LOG2=1): four two-word parameter blocks and seven eight-word main blocks, one copy top-boot and one bottom-boot. At that size every address can be swept after every command. Each sweep checks the full block map of both layouts and the whole lock state of both arrays, so a command that disturbs a neighbouring block or lands on the wrong block shows up at once. Directed steps cover each state transition under both pin levels and the command priority. A long pseudo-random run then mixes commands, pin levels, start strobes and lockout flips.

// File: rtl/flash_lock_pkg.sv
// Shared types for the flash block lock manager.
// Assumes a two-bit state with bit 0 = "writes refused", bit 1 = "held down".
package flash_lock_pkg;

    typedef enum logic [1:0] {
        BLK_UNLOCKED = 2'b00,
        BLK_LOCKED   = 2'b01,
        BLK_DOWN     = 2'b11
    } blk_state_e;

    typedef struct packed {
        logic lock;
        logic unlock;
        logic lockdown;
    } lock_cmd_t;

endpackage

// File: rtl/flash_lock_blkmap.sv
// Maps a word address to a block index for an asymmetric boot-block array.
// Assumes the parameter blocks exactly fill one main-block-sized slot
// (MAIN_LOG2 > PARAM_LOG2) and that the array fills the address space.
module flash_lock_blkmap #(
    parameter int ADDR_W     = 20,
    parameter int MAIN_LOG2  = 15,
    parameter int PARAM_LOG2 = 12,
    parameter bit TOP_BOOT   = 1'b1,
    parameter int IDX_W      = 6
) (
    input  logic [ADDR_W-1:0] word_addr,
    output logic [IDX_W-1:0]  blk_index
);
    localparam int N_PARAM = 1 << (MAIN_LOG2 - PARAM_LOG2);
    localparam int N_MAIN  = (1 << (ADDR_W - MAIN_LOG2)) - 1;
    localparam int N_BLK   = N_PARAM + N_MAIN;
    localparam int SLOT_W  = ADDR_W - MAIN_LOG2;
    localparam int SUB_W   = MAIN_LOG2 - PARAM_LOG2;

    logic [SLOT_W-1:0] slot;
    logic [SUB_W-1:0]  sub;

    assign slot = word_addr[ADDR_W-1:MAIN_LOG2];
    assign sub  = word_addr[MAIN_LOG2-1:PARAM_LOG2];

    generate
        if (TOP_BOOT) begin : g_top
            // Purpose: main blocks low, parameter blocks in the last slot.
            always_comb begin
                if (slot == {SLOT_W{1'b1}})
                    blk_index = IDX_W'(N_MAIN) + IDX_W'(sub);
                else
                    blk_index = IDX_W'(slot);
            end
        end else begin : g_bottom
            // Purpose: parameter blocks in slot 0, main blocks above.
            always_comb begin
                if (slot == '0)
                    blk_index = IDX_W'(sub);
                else
                    blk_index = IDX_W'(N_PARAM) + IDX_W'(slot) - IDX_W'(1);
            end
        end
    endgenerate

    // Purpose: every address must land on an existing block.
    always_comb begin
        assert_idx_range_R1: assert (int'(blk_index) < N_BLK);
    end

endmodule

// File: rtl/flash_lock_cell.sv
// Protection state machine for one block.
// Assumes commands are only honoured when sel is high; priority is
// lock-down, then lock, then unlock.
module flash_lock_cell
    import flash_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  lock_cmd_t  cmd,
    input  logic       wp_pin,
    output blk_state_e state
);
    blk_state_e nxt;
    logic       frozen;

    assign frozen = (state == BLK_DOWN) && !wp_pin;

    // Purpose: next state for the selected block.
    always_comb begin
        nxt = state;
        if (cmd.lockdown)
            nxt = BLK_DOWN;
        else if (cmd.lock && !frozen)
            nxt = BLK_LOCKED;
        else if (cmd.unlock && !frozen)
            nxt = BLK_UNLOCKED;
    end

    // Purpose: state register, locked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= BLK_LOCKED;
        else if (sel)
            state <= nxt;
    end

    assert_reset_locked_R7: assert property (@(posedge clk)
        !rst_n |=> state == BLK_LOCKED);

    assert_lockdown_enters_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel && cmd.lockdown |=> state == BLK_DOWN);

    assert_down_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state == BLK_DOWN && !wp_pin |=> state == BLK_DOWN);

    assert_unsel_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(state));

endmodule

// File: rtl/flash_lock_gate.sv
// Registers the allow/deny verdict when an operation starts.
// Assumes blk_state is the addressed block's state before the start edge;
// the lockout flag is looked at only on that edge.
module flash_lock_gate
    import flash_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_start,
    input  logic       vpp_lockout,
    input  blk_state_e blk_state,
    output logic       verdict_valid,
    output logic       verdict_allow
);
    // Purpose: capture the verdict at start and hold it until the next start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_valid <= 1'b0;
            verdict_allow <= 1'b0;
        end else begin
            verdict_valid <= op_start;
            if (op_start)
                verdict_allow <= !vpp_lockout && (blk_state == BLK_UNLOCKED);
        end
    end

    assert_vpp_deny_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_start && vpp_lockout |=> !verdict_allow);

    assert_verdict_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_start |=> $stable(verdict_allow) && !verdict_valid);

endmodule

// File: rtl/flash_lock_mgr.sv
// Top of the flash block lock manager: address map, one state machine per
// block and the operation verdict register.
// Assumes one word address per cycle; commands and start act on it.
module flash_lock_mgr
    import flash_lock_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int MAIN_LOG2  = 15,
    parameter int PARAM_LOG2 = 12,
    parameter bit TOP_BOOT   = 1'b1,
    parameter int IDX_W      = $clog2((1 << (MAIN_LOG2 - PARAM_LOG2)) +
                                      (1 << (ADDR_W - MAIN_LOG2)) - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic              cmd_lock,
    input  logic              cmd_unlock,
    input  logic              cmd_lockdown,
    input  logic              wp_pin,
    input  logic              vpp_lockout,
    input  logic              op_start,
    output logic [IDX_W-1:0]  blk_index,
    output logic [1:0]        blk_state,
    output logic              verdict_valid,
    output logic              verdict_allow
);
    localparam int N_PARAM = 1 << (MAIN_LOG2 - PARAM_LOG2);
    localparam int N_MAIN  = (1 << (ADDR_W - MAIN_LOG2)) - 1;
    localparam int N_BLK   = N_PARAM + N_MAIN;

    lock_cmd_t  cmd;
    blk_state_e st_all [N_BLK];
    blk_state_e cur_state;

    assign cmd = '{lock: cmd_lock, unlock: cmd_unlock, lockdown: cmd_lockdown};

    flash_lock_blkmap #(
        .ADDR_W    (ADDR_W),
        .MAIN_LOG2 (MAIN_LOG2),
        .PARAM_LOG2(PARAM_LOG2),
        .TOP_BOOT  (TOP_BOOT),
        .IDX_W     (IDX_W)
    ) u_map (
        .word_addr(word_addr),
        .blk_index(blk_index)
    );

    genvar gi;
    generate
        for (gi = 0; gi < N_BLK; gi++) begin : g_cell
            flash_lock_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .sel   (blk_index == IDX_W'(gi)),
                .cmd   (cmd),
                .wp_pin(wp_pin),
                .state (st_all[gi])
            );
        end
    endgenerate

    assign cur_state = st_all[blk_index];
    assign blk_state = cur_state;

    flash_lock_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_start     (op_start),
        .vpp_lockout  (vpp_lockout),
        .blk_state    (cur_state),
        .verdict_valid(verdict_valid),
        .verdict_allow(verdict_allow)
    );

    assert_deny_protected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_start && cur_state != BLK_UNLOCKED |=> !verdict_allow);

    assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> verdict_valid);

endmodule

// File: tb/sim_flash_lock_mgr.sv
// Bench: two small arrays (top- and bottom-boot) swept exhaustively.
module sim_flash_lock_mgr;
    localparam int AW = 6;
    localparam int ML = 3;
    localparam int PL = 1;
    localparam int NP = 1 << (ML - PL);
    localparam int NM = (1 << (AW - ML)) - 1;
    localparam int NB = NP + NM;
    localparam int IW = $clog2(NB);
    localparam int NADDR = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] word_addr = '0;
    logic cmd_lock = 1'b0, cmd_unlock = 1'b0, cmd_lockdown = 1'b0;
    logic wp_pin = 1'b0, vpp_lockout = 1'b0, op_start = 1'b0;
    logic [IW-1:0] idx0, idx1;
    logic [1:0] st0, st1;
    logic val0, val1, alw0, alw1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;
    int m0 [NB];
    int m1 [NB];

    always #5 clk = ~clk;

    flash_lock_mgr #(.ADDR_W(AW), .MAIN_LOG2(ML), .PARAM_LOG2(PL), .TOP_BOOT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .word_addr(word_addr), .cmd_lock(cmd_lock),
        .cmd_unlock(cmd_unlock), .cmd_lockdown(cmd_lockdown), .wp_pin(wp_pin),
        .vpp_lockout(vpp_lockout), .op_start(op_start), .blk_index(idx0),
        .blk_state(st0), .verdict_valid(val0), .verdict_allow(alw0));

    flash_lock_mgr #(.ADDR_W(AW), .MAIN_LOG2(ML), .PARAM_LOG2(PL), .TOP_BOOT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .word_addr(word_addr), .cmd_lock(cmd_lock),
        .cmd_unlock(cmd_unlock), .cmd_lockdown(cmd_lockdown), .wp_pin(wp_pin),
        .vpp_lockout(vpp_lockout), .op_start(op_start), .blk_index(idx1),
        .blk_state(st1), .verdict_valid(val1), .verdict_allow(alw1));

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (addr %0d)", tag, act, exp, word_addr);
        end
    endtask

    // Walk block sizes from address 0 to find the holder of an address.
    function automatic int exp_idx(bit top, int a);
        int base = 0;
        for (int b = 0; b < NB; b++) begin
            int sz;
            if (top) sz = (b < NM) ? (1 << ML) : (1 << PL);
            else     sz = (b < NP) ? (1 << PL) : (1 << ML);
            if (a < base + sz) return b;
            base += sz;
        end
        return -1;
    endfunction

    function automatic int next_st(int s, bit lk, bit ul, bit ld, bit wp);
        bit frozen = (s == 3) && !wp;
        if (ld) return 3;
        if (lk && !frozen) return 1;
        if (ul && !frozen) return 0;
        return s;
    endfunction

    task automatic sweep(string tag);
        for (int a = 0; a < NADDR; a++) begin
            word_addr = AW'(a);
            #1;
            chk(tag, int'(st0), m0[exp_idx(1'b1, a)]);
            chk(tag, int'(st1), m1[exp_idx(1'b0, a)]);
        end
    endtask

    task automatic step(string tag, int a, bit lk, bit ul, bit ld, bit wp, bit st, bit vp);
        int i0 = exp_idx(1'b1, a);
        int i1 = exp_idx(1'b0, a);
        int e0, e1;
        @(negedge clk);
        word_addr = AW'(a);
        cmd_lock = lk; cmd_unlock = ul; cmd_lockdown = ld;
        wp_pin = wp; op_start = st; vpp_lockout = vp;
        e0 = (!vp && m0[i0] == 0) ? 1 : 0;
        e1 = (!vp && m1[i1] == 0) ? 1 : 0;
        @(negedge clk);
        cmd_lock = 0; cmd_unlock = 0; cmd_lockdown = 0; op_start = 0;
        m0[i0] = next_st(m0[i0], lk, ul, ld, wp);
        m1[i1] = next_st(m1[i1], lk, ul, ld, wp);
        if (st) begin
            chk("R10 valid", int'(val0), 1);
            chk("R10 valid", int'(val1), 1);
            chk(vp ? "R9 lockout" : "R8 verdict", int'(alw0), e0);
            chk(vp ? "R9 lockout" : "R8 verdict", int'(alw1), e1);
            vpp_lockout = !vp;
            @(negedge clk);
            chk("R10 hold", int'(val0), 0);
            chk("R10 hold", int'(alw0), e0);
            chk("R10 hold", int'(alw1), e1);
        end
        word_addr = AW'(a);
        #1;
        chk(tag, int'(st0), m0[i0]);
        chk(tag, int'(st1), m1[i1]);
        sweep("R11 others");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int b = 0; b < NB; b++) begin m0[b] = 1; m1[b] = 1; end
        chk("R7 valid", int'(val0), 0);
        chk("R7 allow", int'(alw0), 0);
        chk("R7 allow", int'(alw1), 0);
        sweep("R7 locked");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit [31:0] rng = 32'h1234_5678;
        do_reset();

        // R1 and R2: full address map of both layouts.
        for (int a = 0; a < NADDR; a++) begin
            word_addr = AW'(a);
            #1;
            chk("R2 top map", int'(idx0), exp_idx(1'b1, a));
            chk("R1 bottom map", int'(idx1), exp_idx(1'b0, a));
        end

        // Directed transitions on a parameter block (addr 62) and main block (addr 9).
        step("R3 unlock", 62, 0, 1, 0, 1, 1, 0);
        step("R3 lock", 62, 1, 0, 0, 1, 1, 0);
        step("R3 unlock", 9, 0, 1, 0, 0, 1, 0);
        step("R9 lockout", 9, 0, 0, 0, 0, 1, 1);
        step("R4 down", 9, 0, 0, 1, 0, 1, 0);
        step("R5 unlock ignored", 9, 0, 1, 0, 0, 1, 0);
        step("R5 lock ignored", 9, 1, 0, 0, 0, 0, 0);
        step("R6 unlock", 9, 0, 1, 0, 1, 1, 0);
        step("R4 down", 62, 0, 0, 1, 1, 0, 0);
        step("R6 lock", 62, 1, 0, 0, 1, 0, 0);
        step("R12 lock over unlock", 0, 1, 1, 0, 1, 0, 0);
        step("R12 down wins", 1, 1, 1, 1, 1, 1, 0);
        step("R3 unlock", 1, 0, 1, 0, 0, 0, 0);

        // Pseudo-random mix of commands, pin levels and strobes.
        for (int n = 0; n < 300; n++) begin
            int c;
            rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
            c = int'(rng[10:8]) % 6;
            step("R11 random", int'(rng[5:0]), c == 0 || c == 3, c == 1 || c == 3 || c == 5,
                 c == 2, rng[12], rng[13], rng[15:14] == 2'b00);
        end

        do_reset();

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule